// File: doc/BRIEF.md
# Dual-Format Signed Adder

This block adds or subtracts two signed operands held either in two's complement or in one's complement form. The format and the operation are chosen for each transfer. An operand pair enters on a valid/ready handshake. One clock later the block presents the result on a second valid/ready handshake. The result comes with a carry flag, an overflow flag and a flag for the negative-zero encoding.

In two's complement format, subtraction inverts the second operand and injects a carry of one into bit 0. In one's complement format, subtraction only inverts the second operand. Any carry leaving the top bit is then folded back into bit 0 within the same operation, so both encodings of zero are handled correctly. Overflow in two's complement format follows the carry relation at the top bit. In one's complement format it follows the sign rule on the effective operands.

The width is a parameter with a default of 8 bits, and the block is intended for use at that width.

Top module: `dual_fmt_adder`

## Requirements
- R1: `in_ready` is high exactly when no result is held or the held result is being taken (`out_valid` low or `out_ready` high). An operand pair accepted on a clock edge appears with `out_valid` high after that edge. A held result and its flags stay unchanged until `out_ready` is high.
- R2: With `ones_mode`=0 and `subtract`=0, `sum` is (`op_a`+`op_b`) mod 256, and `carry` is bit 8 of that addition.
- R3: With `ones_mode`=0, `overflow` is the XOR of the carry into bit 7 and the carry out of bit 7. It is therefore set only when the effective operands have the same sign and `sum` has the other sign. A carry out of bit 7 on its own does not set it.
- R4: With `ones_mode`=0 and `subtract`=1, `sum` is (`op_a` + ~`op_b` + 1) mod 256, which equals `op_a`-`op_b` mod 256, and `carry` is bit 8 of that addition.
- R5: With `ones_mode`=1 and `subtract`=0, the raw total `op_a`+`op_b` has its bit 8 added back into bit 0, giving `sum`. `carry` reports that folded bit. For example, 1111_0011 (-12) + 0000_1101 (+13) gives 0000_0001 with `carry`=1.
- R6: With `ones_mode`=1 and `subtract`=1, the second operand is bit-inverted and no carry of one is injected. The end-around fold of R5 then applies.
- R7: With `ones_mode`=1, `overflow` is set when `op_a` and the effective second operand have the same sign bit and `sum` has a different sign bit.
- R8: `neg_zero` is set when `ones_mode`=1 and `sum` is 1111_1111. It is never set when `ones_mode`=0.
- R9: While `rst_n` is low, and right after it is released, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operand pair is offered |
| in_ready | output | 1 | The block can take the offered pair |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| ones_mode | input | 1 | 0 = two's complement format, 1 = one's complement format |
| subtract | input | 1 | 0 = add, 1 = subtract the second operand |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the presented result |
| sum | output | W | Result |
| carry | output | 1 | Carry out of the top bit (the folded bit in one's complement format) |
| overflow | output | 1 | Signed overflow for the selected format |
| neg_zero | output | 1 | Result is the all-ones negative zero (one's complement format only) |

## Verification
The bench builds the block at its default width of 8 bits. At that width the whole operand space is small enough for random operand pairs, in both formats and both operations, to reach the sign boundaries, the carry-without-overflow cases and the all-ones results. Directed pairs add the two known overflow vectors and the -12 + 13 end-around case. They also cover subtraction of 0x80 and x - x in one's complement format, which lands on negative zero. A random consumer stall stream keeps results waiting across several clocks, so that acceptance during a held result and the stability of held flags are both exercised.

// File: rtl/dfa_pkg.sv
package dfa_pkg;

  typedef enum logic {
    FMT_TWOS = 1'b0,
    FMT_ONES = 1'b1
  } num_fmt_e;

  // One bit position of the adder: returns {carry_out, sum_bit}.
  function automatic logic [1:0] bit_add(input logic x, input logic y, input logic ci);
    logic s;
    logic co;
    s  = x ^ y ^ ci;
    co = (x & y) | (x & ci) | (y & ci);
    return {co, s};
  endfunction

  // Sign rule: operands agree in sign and the result disagrees.
  function automatic logic sign_flip(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

endpackage

// File: rtl/dfa_operand_prep.sv
module dfa_operand_prep
  import dfa_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  num_fmt_e       fmt,
  input  logic           sub,
  input  logic [W-1:0]   b_in,
  output logic [W-1:0]   b_eff,
  output logic           cin
);

  // Subtraction inverts the second operand in both formats; only the
  // two's complement format adds the extra one through the carry input.
  always_comb begin
    b_eff = sub ? ~b_in : b_in;
    cin   = sub && (fmt == FMT_TWOS);
  end

endmodule

// File: rtl/dfa_ripple.sv
module dfa_ripple
  import dfa_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic [W:0]   cvec
);

  assign cvec[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] fa;
    assign fa        = bit_add(a[i], b[i], cvec[i]);
    assign s[i]      = fa[0];
    assign cvec[i+1] = fa[1];
  end

endmodule

// File: rtl/dfa_fixup.sv
module dfa_fixup
  import dfa_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  num_fmt_e       fmt,
  input  logic [W-1:0]   raw,
  input  logic           cout,
  input  logic           a_msb,
  input  logic           b_msb,
  output logic [W-1:0]   res,
  output logic           carry_flag,
  output logic           ovf,
  output logic           nz
);

  logic          wrap;
  logic [W:0]    inc_c;

  assign wrap     = (fmt == FMT_ONES) && cout;
  assign inc_c[0] = wrap;

  // End-around increment: a half-adder chain fed by the folded carry.
  // The raw total never exceeds 2*(2^W-1), so this chain cannot carry out.
  for (genvar i = 0; i < W; i++) begin : g_inc
    logic [1:0] ha;
    assign ha         = bit_add(raw[i], 1'b0, inc_c[i]);
    assign res[i]     = ha[0];
    assign inc_c[i+1] = ha[1];
  end

  always_comb begin
    carry_flag = cout;
    ovf        = sign_flip(a_msb, b_msb, res[W-1]);
    nz         = (fmt == FMT_ONES) && (&res);
  end

endmodule

// File: rtl/dual_fmt_adder.sv
module dual_fmt_adder
  import dfa_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         ones_mode,
  input  logic         subtract,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         overflow,
  output logic         neg_zero
);

  localparam int unsigned MSB = W - 1;

  num_fmt_e     fmt;
  logic [W-1:0] b_eff;
  logic         cin;
  logic [W-1:0] raw;
  logic [W:0]   cvec;
  logic [W-1:0] res_next;
  logic         carry_next;
  logic         ovf_next;
  logic         nz_next;

  // Named internal events observed by the checker.
  logic         accept;
  logic         c_into_msb;
  logic         c_out_msb;

  assign fmt = num_fmt_e'(ones_mode);

  dfa_operand_prep #(.W(W)) i_prep (
    .fmt   (fmt),
    .sub   (subtract),
    .b_in  (op_b),
    .b_eff (b_eff),
    .cin   (cin)
  );

  dfa_ripple #(.W(W)) i_ripple (
    .a    (op_a),
    .b    (b_eff),
    .cin  (cin),
    .s    (raw),
    .cvec (cvec)
  );

  assign c_into_msb = cvec[MSB];
  assign c_out_msb  = cvec[W];

  dfa_fixup #(.W(W)) i_fixup (
    .fmt        (fmt),
    .raw        (raw),
    .cout       (c_out_msb),
    .a_msb      (op_a[MSB]),
    .b_msb      (b_eff[MSB]),
    .res        (res_next),
    .carry_flag (carry_next),
    .ovf        (ovf_next),
    .nz         (nz_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
      carry     <= 1'b0;
      overflow  <= 1'b0;
      neg_zero  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      sum       <= res_next;
      carry     <= carry_next;
      overflow  <= ovf_next;
      neg_zero  <= nz_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/dfa_checker.sv
module dfa_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] op_a,
  input logic [W-1:0] b_eff,
  input logic         ones_mode,
  input logic         accept,
  input logic         c_into_msb,
  input logic         c_out_msb,
  input logic         ovf_next,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] sum,
  input logic         carry,
  input logic         overflow,
  input logic         neg_zero
);

  a_r1_accept_presents: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r1_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(sum) && $stable(carry) && $stable(overflow) && $stable(neg_zero)));

  // R3: the sign rule used by the flag unit must agree with the carry relation.
  a_r3_carry_relation: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ones_mode) |-> (ovf_next == (c_into_msb ^ c_out_msb)));

  a_r7_opposite_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ones_mode && (op_a[W-1] != b_eff[W-1])) |=> !overflow);

  a_r8_two_no_negzero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ones_mode) |=> !neg_zero);

  a_r8_negzero_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && neg_zero) |-> (&sum));

endmodule

bind dual_fmt_adder dfa_checker #(.W(W)) i_dfa_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .op_a       (op_a),
  .b_eff      (b_eff),
  .ones_mode  (ones_mode),
  .accept     (accept),
  .c_into_msb (c_into_msb),
  .c_out_msb  (c_out_msb),
  .ovf_next   (ovf_next),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .sum        (sum),
  .carry      (carry),
  .overflow   (overflow),
  .neg_zero   (neg_zero)
);

// File: tb/test_dual_fmt_adder.sv
`timescale 1ns/1ps
module test_dual_fmt_adder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] op_a = '0;
  logic [7:0] op_b = '0;
  logic       ones_mode = 1'b0;
  logic       subtract = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] sum;
  logic       carry;
  logic       overflow;
  logic       neg_zero;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  bp_en   = 1'b0;
  bit  mon_en  = 1'b0;
  bit  acc_prev = 1'b0;

  typedef struct packed {
    logic [7:0] s;
    logic       c;
    logic       ov;
    logic       nz;
    logic       ones;
    logic       sub;
  } exp_t;

  exp_t q[$];

  always #2 clk = ~clk;

  dual_fmt_adder i_dual_fmt_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .ones_mode(ones_mode), .subtract(subtract),
    .out_valid(out_valid), .out_ready(out_ready), .sum(sum), .carry(carry),
    .overflow(overflow), .neg_zero(neg_zero)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference written from the requirements.
  function automatic exp_t model(input int a, input int b, input bit ones, input bit sub);
    exp_t e;
    int beff, tot, s, sa, sb, r;
    beff = sub ? ((~b) & 255) : b;
    e.ones = ones;
    e.sub  = sub;
    if (!ones) begin
      tot  = a + beff + (sub ? 1 : 0);
      s    = tot & 255;
      e.c  = tot > 255;
      sa   = (a > 127) ? a - 256 : a;
      sb   = (b > 127) ? b - 256 : b;
      r    = sub ? sa - sb : sa + sb;
      e.ov = (r > 127) || (r < -128);
      e.nz = 1'b0;
    end else begin
      tot  = a + beff;
      e.c  = tot > 255;
      s    = e.c ? ((tot - 255) & 255) : tot;
      e.ov = (((a >> 7) & 1) == ((beff >> 7) & 1)) && (((s >> 7) & 1) != ((a >> 7) & 1));
      e.nz = (s == 255);
    end
    e.s = s[7:0];
    return e;
  endfunction

  // Monitor: samples on the falling edge, between driving and the next rising edge.
  always @(negedge clk) begin
    if (mon_en) begin
      check(in_ready == (!out_valid || out_ready), "R1 ready", in_ready, !out_valid || out_ready);
      if (acc_prev) check(out_valid == 1'b1, "R1 latency", out_valid, 1);
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R1 spurious result", 1, 0);
        end else begin
          exp_t e;
          string tag;
          e = q[0];
          tag = e.ones ? (e.sub ? "R6" : "R5") : (e.sub ? "R4" : "R2");
          check(sum == e.s,   {tag, " sum"},   sum, e.s);
          check(carry == e.c, {tag, " carry"}, carry, e.c);
          check(overflow == e.ov, e.ones ? "R7 overflow" : "R3 overflow", overflow, e.ov);
          check(neg_zero == e.nz, "R8 neg_zero", neg_zero, e.nz);
        end
        if (out_ready && q.size() != 0) void'(q.pop_front());
      end
      acc_prev = in_valid && in_ready;
      if (acc_prev) q.push_back(model(op_a, op_b, ones_mode, subtract));
    end
  end

  // Consumer stall stream.
  always @(posedge clk) begin
    #1;
    out_ready <= bp_en ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic send(input logic [7:0] a, input logic [7:0] b, input bit ones, input bit sub);
    @(posedge clk);
    #1;
    in_valid  = 1'b1;
    op_a      = a;
    op_b      = b;
    ones_mode = ones;
    subtract  = sub;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic run_all();
    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R9 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
    mon_en = 1'b1;

    send(8'h7C, 8'h5A, 0, 0);   // R3: 124+90 overflows to 0xD6
    send(8'h99, 8'hD0, 0, 0);   // R3: -103 + -48 overflows to 0x69, carry set
    send(8'hFF, 8'h01, 0, 0);   // R3: carry without overflow
    send(8'h80, 8'h01, 0, 1);   // R4: -128 - 1 overflows
    send(8'h05, 8'h80, 0, 1);   // R4: subtracting -128
    send(8'hF3, 8'h0D, 1, 0);   // R5: -12 + 13 = +1 with end-around
    send(8'h25, 8'h25, 1, 1);   // R6/R8: x - x gives negative zero
    send(8'hFF, 8'hFF, 1, 0);   // R8: -0 + -0
    send(8'h7F, 8'h01, 1, 0);   // R7: like signs, overflow
    send(8'h80, 8'h80, 1, 0);   // R7: -127 + -127 overflows
    send(8'h40, 8'hC0, 1, 1);   // R6: subtract negative operand
    send(8'h00, 8'h00, 0, 1);   // R4: 0 - 0, carry set

    // Back-to-back transfers while results stall.
    bp_en = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      send(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    end
    bp_en = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(q.size() == 0, "R1 all results delivered", q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog: actual hung expected finished");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule